// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a 10-bit successive-approximation converter. A programmable divider derives a slower converter clock from the system clock. Once enabled, the sequencer waits for a start request. On the next rising converter-clock edge it latches the channel and reference selections and runs one conversion. Part way through, it sends out a single-cycle sample-and-hold strobe. It then works out the result one bit per converter clock, MSB first, by driving a trial code to the external DAC and reading back one comparator bit.

At completion the result register is loaded, a sticky done flag is raised and the start request drops, all on the same edge. The first conversion after the enable rises takes a long path of 25 converter cycles while the analog side settles. Later conversions take 13 cycles. Every pin is a plain register-style control or status signal. The result is held in a register that software reads at its own pace, so the block applies no back-pressure and has no valid/ready handshake.

Top module: `adc_seq_ctrl`

## Requirements
- R1: `div_sel_i` sets the converter clock period D in system clocks: codes 0 and 1 give 2, and each code k from 2 to 7 gives 2^k. All conversion timing scales with D.
- R2: A start request is taken on the first rising converter-clock edge after `start_o` has become 1. The strobe therefore comes out 1.5·D+2 to 2.5·D+1 system cycles after the request is sampled on a normal conversion, or 13.5·D+2 to 14.5·D+1 cycles after it on a first conversion.
- R3: A normal conversion lasts 13 converter cycles. `sh_o` pulses 1.5 converter cycles after the start, and `flag_o` rises exactly 11.5·D system cycles after `sh_o`.
- R4: The first conversion after the enable rises lasts 25 converter cycles, with `sh_o` 13.5 cycles after the start. The gap from `sh_o` to `flag_o` is again 11.5·D.
- R5: `cmp_i`=1 means the analog input is at least `dac_code_o`. The trial bit is kept on a 1 and cleared on a 0, from bit 9 down to bit 0. `result_o` then equals the input code for every code from 0 to 1023.
- R6: At completion `result_o` is written and `flag_o` sets on the same edge that clears `start_o`.
- R7: `flag_o` stays at 1 until a cycle with `flag_clr_i`=1. If completion and clear fall in the same cycle, the flag is set.
- R8: Dropping `en_i` aborts a running conversion with no flag and no result, and the next conversion takes the 25-cycle path.
- R9: `chan_o` and `ref_o` take `chan_sel_i` and `ref_sel_i` when a conversion starts, and hold them until the next start.
- R10: `start_set_i` has no effect while `en_i`=0: `start_o` stays 0, and no conversion runs after the enable returns.
- R11: After reset `flag_o`, `start_o`, `sh_o` and `result_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Converter enable; 0 aborts and holds the divider in reset |
| start_set_i | input | 1 | Pulse that sets the start request |
| flag_clr_i | input | 1 | Pulse that clears the done flag |
| div_sel_i | input | 3 | Converter clock divide select |
| chan_sel_i | input | 4 | Channel select, latched at start |
| ref_sel_i | input | 2 | Reference select, latched at start |
| cmp_i | input | 1 | Comparator: input at least the trial code |
| start_o | output | 1 | Start request (busy until completion) |
| flag_o | output | 1 | Sticky done flag |
| result_o | output | 10 | Last conversion result |
| dac_code_o | output | 10 | Trial code for the DAC |
| sh_o | output | 1 | Sample-and-hold strobe, one system cycle |
| chan_o | output | 4 | Latched channel for the input mux |
| ref_o | output | 2 | Latched reference select |

## Verification
The bench uses the default 10-bit result width and 7-bit divider counter, so every code from 0 to 1023 can be produced and all eight divide codes are legal. It runs most conversions with divide codes 0 and 1, where D is 2, to keep them short. Codes 3 and 7 give D of 8 and 128, which shows that the strobe-to-flag gap of 11.5·D and the start window scale with the divider. The largest ratio also drives the divider counter to its top value.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  parameter int unsigned ADC_RES_W  = 10;
  parameter int unsigned NORM_SH    = 2;   // converter cycle holding the mid-cycle sample
  parameter int unsigned NORM_LAST  = 13;
  parameter int unsigned FIRST_SH   = 14;
  parameter int unsigned FIRST_LAST = 25;
  typedef logic [ADC_RES_W-1:0] adc_code_t;
endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             rise_o,
  output logic             fall_o
);
  localparam int unsigned DIV_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] shift;
  logic [DIV_W-1:0] div, half, cnt_x;

  always_comb begin
    shift  = (sel_i == '0) ? SEL_W'(1) : sel_i;
    div    = DIV_W'(1) << shift;
    half   = div >> 1;
    cnt_x  = {1'b0, cnt_q};
    rise_o = en_i && (cnt_x >= div - DIV_W'(1));
    fall_o = en_i && (cnt_x == half - DIV_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (rise_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end

  // R1: the rising and falling ticks of the converter clock never coincide
  p_tick_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |-> !fall_o);
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_W = ADC_RES_W,
  parameter int unsigned CYC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             go_i,
  input  logic             first_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic             launch_o,
  output logic             done_o,
  output logic             sh_o,
  output logic [RES_W-1:0] sar_o
);
  localparam logic [RES_W-1:0] MSB = {1'b1, {(RES_W-1){1'b0}}};

  logic             busy_q, long_q, sh_q;
  logic [CYC_W-1:0] cyc_q, sh_c, last_c;
  logic [RES_W-1:0] sar_q, mask_q;
  logic             sample_t, decide_t;

  always_comb begin
    sh_c     = long_q ? CYC_W'(FIRST_SH)   : CYC_W'(NORM_SH);
    last_c   = long_q ? CYC_W'(FIRST_LAST) : CYC_W'(NORM_LAST);
    launch_o = en_i && !busy_q && go_i && rise_i;
    done_o   = busy_q && rise_i && (cyc_q == last_c);
    sample_t = busy_q && fall_i && (cyc_q == sh_c);
    decide_t = busy_q && rise_i && (mask_q != '0) && (cyc_q > sh_c);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; long_q <= 1'b0; sh_q <= 1'b0;
      cyc_q  <= '0;   sar_q  <= '0;   mask_q <= '0;
    end else if (!en_i) begin
      busy_q <= 1'b0; sh_q <= 1'b0;
      cyc_q  <= '0;   sar_q <= '0;   mask_q <= '0;
    end else begin
      sh_q <= sample_t;
      if (launch_o) begin
        busy_q <= 1'b1;
        cyc_q  <= CYC_W'(1);
        long_q <= first_i;
      end else if (done_o) begin
        busy_q <= 1'b0;
        cyc_q  <= '0;
      end else if (busy_q && rise_i) begin
        cyc_q  <= cyc_q + CYC_W'(1);
      end
      if (sample_t) begin
        sar_q  <= MSB;
        mask_q <= MSB;
      end else if (decide_t) begin
        sar_q  <= (cmp_i ? sar_q : (sar_q & ~mask_q)) | (mask_q >> 1);
        mask_q <= mask_q >> 1;
      end
    end
  end

  assign busy_o = busy_q;
  assign sh_o   = sh_q;
  assign sar_o  = sar_q;

  // R3: the sample strobe only appears inside a running conversion
  p_sh_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sh_q |-> busy_q);
  // R5: exactly one trial bit under test at a time
  p_mask_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_q));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_W  = ADC_RES_W,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned CNT_W  = 7,
  parameter int unsigned CHAN_W = 4,
  parameter int unsigned REF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              start_set_i,
  input  logic              flag_clr_i,
  input  logic [SEL_W-1:0]  div_sel_i,
  input  logic [CHAN_W-1:0] chan_sel_i,
  input  logic [REF_W-1:0]  ref_sel_i,
  input  logic              cmp_i,
  output logic              start_o,
  output logic              flag_o,
  output logic [RES_W-1:0]  result_o,
  output logic [RES_W-1:0]  dac_code_o,
  output logic              sh_o,
  output logic [CHAN_W-1:0] chan_o,
  output logic [REF_W-1:0]  ref_o
);
  localparam int unsigned CYC_W = $clog2(FIRST_LAST + 1);

  logic              rise, fall, busy, launch, done;
  logic              start_q, flag_q, first_q;
  logic [RES_W-1:0]  sar, result_q;
  logic [CHAN_W-1:0] chan_q;
  logic [REF_W-1:0]  ref_q;

  adc_prescaler #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_div (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .sel_i(div_sel_i),
    .rise_o(rise), .fall_o(fall)
  );

  adc_sar_seq #(.RES_W(RES_W), .CYC_W(CYC_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .rise_i(rise), .fall_i(fall),
    .go_i(start_q), .first_i(first_q), .cmp_i(cmp_i),
    .busy_o(busy), .launch_o(launch), .done_o(done), .sh_o(sh_o), .sar_o(sar)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= 1'b0;
      flag_q   <= 1'b0;
      first_q  <= 1'b1;
      result_q <= '0;
      chan_q   <= '0;
      ref_q    <= '0;
    end else begin
      if (!en_i)            start_q <= 1'b0;
      else if (done)        start_q <= 1'b0;
      else if (start_set_i) start_q <= 1'b1;

      if (done)            flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;

      if (!en_i)     first_q <= 1'b1;
      else if (done) first_q <= 1'b0;

      if (done) result_q <= sar;
      if (launch) begin
        chan_q <= chan_sel_i;
        ref_q  <= ref_sel_i;
      end
    end
  end

  assign start_o    = start_q;
  assign flag_o     = flag_q;
  assign result_o   = result_q;
  assign dac_code_o = sar;
  assign chan_o     = chan_q;
  assign ref_o      = ref_q;

  // R6: the request is gone on the edge the flag rises
  p_req_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> !start_q);
  // R6: the result only moves together with a set flag
  p_result_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result_q) |-> flag_q);
  // R7: flag holds without a clear
  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !flag_clr_i |=> flag_q);
  // R8: disable leaves nothing running or pending
  p_off_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !busy && !start_q);
  // R9: latched selections hold through a conversion
  p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(chan_q) && $stable(ref_q));
endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, start_set = 1'b0, flag_clr = 1'b0;
  logic [2:0] div_sel = 3'd0;
  logic [3:0] chan_sel = 4'd0;
  logic [1:0] ref_sel = 2'd0;
  logic       cmp;
  logic       start_o, flag_o, sh_o;
  logic [9:0] result_o, dac_code_o;
  logic [3:0] chan_o;
  logic [1:0] ref_o;
  int         vin_r = 0;
  int         checks = 0, fails = 0;
  bit         finished = 0;

  always #10 clk = ~clk;

  // ideal comparator: input at least the trial code
  assign cmp = (int'(dac_code_o) <= vin_r);

  adc_seq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .start_set_i(start_set),
    .flag_clr_i(flag_clr), .div_sel_i(div_sel), .chan_sel_i(chan_sel),
    .ref_sel_i(ref_sel), .cmp_i(cmp), .start_o(start_o), .flag_o(flag_o),
    .result_o(result_o), .dac_code_o(dac_code_o), .sh_o(sh_o),
    .chan_o(chan_o), .ref_o(ref_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  // one conversion; checks start window, strobe-to-flag gap, result, request clear
  task automatic do_conv(input int vin, input bit first, input int d,
                         input int new_chan, input string tag);
    int n = 0, n_sh = -1, n_fl = -1, lo, hi, old_chan;
    bit prev_start = 0;
    vin_r = vin;
    old_chan = int'(chan_sel);
    @(negedge clk); start_set = 1'b1;
    while (n_fl < 0 && n < 40 * d + 200) begin
      @(negedge clk); start_set = 1'b0; n++;
      if (n == 10 && new_chan >= 0) chan_sel = 4'(new_chan);
      if (sh_o && n_sh < 0) n_sh = n;
      if (flag_o && n_fl < 0) begin
        n_fl = n;
        check(start_o == 1'b0 && prev_start, {tag, " R6 request clears with flag"},
              int'(start_o), 0);
      end
      prev_start = start_o;
    end
    lo = first ? (27 * d) / 2 + 2 : (3 * d) / 2 + 2;
    hi = lo + d - 1;
    check(n_sh >= lo && n_sh <= hi,
          {tag, first ? " R2 R4 first-path strobe window" : " R2 R3 strobe window"}, n_sh, lo);
    check(n_fl - n_sh == (23 * d) / 2,
          {tag, first ? " R4 strobe to flag" : " R3 strobe to flag"}, n_fl - n_sh, (23 * d) / 2);
    check(int'(result_o) == vin, {tag, " R5 result"}, int'(result_o), vin);
    if (new_chan >= 0)
      check(int'(chan_o) == old_chan, {tag, " R9 channel held"}, int'(chan_o), old_chan);
  endtask

  task automatic t_reset();
    check(flag_o == 0 && start_o == 0 && sh_o == 0 && result_o == 0,
          "R11 reset state", int'(result_o) + int'(flag_o) + int'(start_o), 0);
  endtask

  task automatic t_first_and_normal();
    en = 1'b1; div_sel = 3'd0;
    do_conv(700, 1, 2, -1, "first");
    clr_flag(); do_conv(0, 0, 2, -1, "zero");
    clr_flag(); do_conv(1023, 0, 2, -1, "full");
    clr_flag(); do_conv(341, 0, 2, -1, "alt");
  endtask

  task automatic t_sticky();
    repeat (20) @(negedge clk);
    check(flag_o == 1'b1, "R7 flag sticky", int'(flag_o), 1);
    clr_flag();
    check(flag_o == 1'b0, "R7 flag cleared", int'(flag_o), 0);
  endtask

  task automatic t_prescale();
    div_sel = 3'd1; do_conv(512, 0, 2, -1, "sel1 R1");
    clr_flag(); div_sel = 3'd3; do_conv(100, 0, 8, -1, "sel3 R1");
    clr_flag(); div_sel = 3'd7; do_conv(901, 0, 128, -1, "sel7 R1");
    clr_flag(); div_sel = 3'd0;
  endtask

  task automatic t_latch();
    chan_sel = 4'd5; ref_sel = 2'd1;
    do_conv(77, 0, 2, 9, "latch");
    check(ref_o == 2'd1, "R9 reference latched", int'(ref_o), 1);
    clr_flag(); do_conv(78, 0, 2, -1, "relatch");
    check(chan_o == 4'd9, "R9 new channel next start", int'(chan_o), 9);
    clr_flag();
  endtask

  task automatic t_abort();
    @(negedge clk); start_set = 1'b1;
    @(negedge clk); start_set = 1'b0;
    repeat (12) @(negedge clk);
    en = 1'b0;
    repeat (30) @(negedge clk);
    check(flag_o == 1'b0 && start_o == 1'b0, "R8 abort leaves no flag",
          int'(flag_o) + int'(start_o), 0);
    en = 1'b1;
    repeat (3) @(negedge clk);
    do_conv(250, 1, 2, -1, "after abort R8");
    clr_flag();
  endtask

  task automatic t_disabled_start();
    en = 1'b0;
    @(negedge clk); start_set = 1'b1;
    @(negedge clk); start_set = 1'b0;
    check(start_o == 1'b0, "R10 start ignored while off", int'(start_o), 0);
    repeat (100) @(negedge clk);
    en = 1'b1;
    repeat (80) @(negedge clk);
    check(flag_o == 1'b0 && start_o == 1'b0, "R10 no conversion after enable",
          int'(flag_o) + int'(start_o), 0);
    do_conv(600, 1, 2, -1, "after ignore R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_first_and_normal();
    t_sticky();
    t_prescale();
    t_latch();
    t_abort();
    t_disabled_start();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule